// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block applies gamma correction to the pixels of three independent display channels. Each channel has three tables, one for each of red, green and blue. Each table has one entry for every possible component value. Each component of an incoming pixel selects an entry in the table for its channel and colour. The entry's value is presented on the output one clock later. When a channel has its gamma enable low, its pixels bypass the tables and leave after the same one-cycle delay.

Software fills the tables through a two-register port, which is selected by `regSel`. A write to the pointer register (`regSel`=0) sets the table index from its low bits. The same write sets an auto-advance flag from bit 31 and a keep-powered flag from bit 30. A write to the data register (`regSel`=1) stores its low bits at the current index. When auto-advance is on, that write also moves the index forward by one.

The tables are powered only while at least one channel has gamma enabled or the keep-powered flag is set. Whenever they are unpowered, their contents are lost.

Top module: `gamma_lut_top`

## Requirements
- R1: Reset (synchronous, `rstN` low) clears `pixOut`, every table entry, the table index, the auto-advance flag and the keep-powered flag. A data write after reset, with no pointer write, lands at index 0 and leaves the index there.
- R2: The table for channel c and colour k (0 red, 1 green, 2 blue) occupies indices (c*3+k)*E to (c*3+k)*E+E-1, where E = 2^DATA_W. Entry v is at index (c*3+k)*E+v, so channel c starts at c*3*E (768*c for 8-bit data). On `pixIn` and `pixOut`, component k of channel c sits at bits starting at (c*3+k)*DATA_W.
- R3: With bit 31 set by the last pointer write, each data write advances the index by one. From the last index (3*NUM_CH*E-1), or from any higher value, the index goes to 0. With bit 31 clear, the index does not move.
- R4: With the gamma enable of channel c high, each output component of that channel equals the entry selected by the input component one cycle earlier. With the enable low, the output equals the input one cycle earlier.
- R5: The tables are powered while any gamma enable is high or bit 30 of the last pointer write is set. A data write while they are unpowered stores nothing, although the index still advances.
- R6: After any cycle in which the tables are unpowered, every entry reads as zero until it is rewritten.
- R7: While bit 30 is set, the table contents survive a period in which all gamma enables are low.
- R8: A data write to the table that a component of an enabled channel is reading in the same cycle takes priority. That component's output then repeats its previous value for that cycle. The other components are unaffected.
- R9: A data write while the index is at or beyond 3*NUM_CH*E stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the pointer register, 1 selects the data register |
| regWrData | input | 32 | Register write value |
| gammaEn | input | NUM_CH | Per-channel gamma enable |
| pixIn | input | NUM_CH*3*DATA_W | Input components, packed as in R2 |
| pixOut | output | NUM_CH*3*DATA_W | Corrected or bypassed components, one cycle later |

## Verification
The bench builds the block with NUM_CH=3 and DATA_W=4. This gives 16-entry tables and 144 indices in all. With that size the bench can load every entry of every table and then cross the wrap from index 143 to 0 in a short run. It can also place the pointer at an unused index (150) that still fits in the 8-bit index field. The power-loss, keep-powered and write-collision cases are each driven with exact cycle alignment. The bench keeps an independent model of the tables to predict every component.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int COLOURS = 3;

  typedef struct packed {
    logic tableWr;
    logic powerOn;
  } lutStrobe_t;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        regWrEn,
  input  logic                                        regSel,
  input  logic [31:0]                                 regWrData,
  input  logic [NUM_CH-1:0]                           gammaEn,
  output lutStrobe_t                                  strobe,
  output logic [$clog2(NUM_CH*COLOURS*(1<<DATA_W))-1:0] wrAddr,
  output logic [DATA_W-1:0]                           wrData
);
  localparam int ENTRIES = 1 << DATA_W;
  localparam int TOTAL   = NUM_CH * COLOURS * ENTRIES;
  localparam int AW      = $clog2(TOTAL);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [AW-1:0] ptr;
  logic          autoInc;
  logic          forceOn;
  logic          dataWr;
  logic          unusedRegBits;

  assign dataWr        = regWrEn && regSel;
  assign unusedRegBits = &{1'b0, regWrData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      autoInc <= 1'b0;
      forceOn <= 1'b0;
    end else if (regWrEn && !regSel) begin
      ptr     <= regWrData[AW-1:0];
      autoInc <= regWrData[31];
      forceOn <= regWrData[30];
    end else if (dataWr && autoInc) begin
      ptr <= (ptr >= LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_comb begin
    strobe.powerOn = forceOn || (|gammaEn);
    strobe.tableWr = dataWr && strobe.powerOn && (ptr <= LAST);
  end

  assign wrAddr = ptr;
  assign wrData = regWrData[DATA_W-1:0];
endmodule

// File: rtl/gamma_lut_datapath.sv
module gamma_lut_datapath
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  lutStrobe_t                                  strobe,
  input  logic [$clog2(NUM_CH*COLOURS*(1<<DATA_W))-1:0] wrAddr,
  input  logic [DATA_W-1:0]                           wrData,
  input  logic [NUM_CH-1:0]                           gammaEn,
  input  logic [NUM_CH*COLOURS*DATA_W-1:0]            pixIn,
  output logic [NUM_CH*COLOURS*DATA_W-1:0]            pixOut
);
  localparam int ENTRIES = 1 << DATA_W;
  localparam int BANKS   = NUM_CH * COLOURS;
  localparam int AW      = $clog2(BANKS * ENTRIES);
  localparam int BW      = AW - DATA_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int CH = b / COLOURS;
    logic [DATA_W-1:0] mem [ENTRIES];
    logic [DATA_W-1:0] comp;
    logic [DATA_W-1:0] outReg;
    logic              hit;

    assign comp = pixIn[b*DATA_W +: DATA_W];
    assign hit  = strobe.tableWr && (wrAddr[AW-1:DATA_W] == BW'(b));

    always_ff @(posedge clk) begin
      if (!rstN || !strobe.powerOn) begin
        for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (hit) begin
        mem[wrAddr[DATA_W-1:0]] <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outReg <= '0;
      end else if (!gammaEn[CH]) begin
        outReg <= comp;
      end else if (!hit) begin
        outReg <= mem[comp];
      end
    end

    assign pixOut[b*DATA_W +: DATA_W] = outReg;
  end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWrEn,
  input  logic                             regSel,
  input  logic [31:0]                      regWrData,
  input  logic [NUM_CH-1:0]                gammaEn,
  input  logic [NUM_CH*COLOURS*DATA_W-1:0] pixIn,
  output logic [NUM_CH*COLOURS*DATA_W-1:0] pixOut
);
  localparam int AW = $clog2(NUM_CH * COLOURS * (1 << DATA_W));

  lutStrobe_t        ctrlStb;
  logic [AW-1:0]     wrAddr;
  logic [DATA_W-1:0] wrData;

  gamma_lut_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .gammaEn(gammaEn), .strobe(ctrlStb),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  gamma_lut_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(ctrlStb), .wrAddr(wrAddr),
    .wrData(wrData), .gammaEn(gammaEn), .pixIn(pixIn), .pixOut(pixOut)
  );
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input logic                                        clk,
  input logic                                        rstN,
  input logic                                        regWrEn,
  input logic                                        regSel,
  input logic [NUM_CH-1:0]                           gammaEn,
  input logic [NUM_CH*COLOURS*DATA_W-1:0]            pixIn,
  input logic [NUM_CH*COLOURS*DATA_W-1:0]            pixOut,
  input lutStrobe_t                                  ctrlStb,
  input logic [$clog2(NUM_CH*COLOURS*(1<<DATA_W))-1:0] wrAddr
);
  localparam int BANKS = NUM_CH * COLOURS;
  localparam int AW    = $clog2(BANKS * (1 << DATA_W));
  localparam int BW    = AW - DATA_W;
  localparam logic [AW-1:0] LAST = AW'(BANKS * (1 << DATA_W) - 1);

  // R3: index wrap and advance
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && wrAddr >= LAST) |=> (wrAddr == '0 || $stable(wrAddr)));
  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && wrAddr < LAST) |=> (wrAddr == $past(wrAddr) + 1'b1 || $stable(wrAddr)));

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    localparam int CH = b / COLOURS;
    logic bankHit;
    assign bankHit = ctrlStb.tableWr && (wrAddr[AW-1:DATA_W] == BW'(b));

    // R4: bypass keeps the value with one cycle of delay
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
      !gammaEn[CH] |=> pixOut[b*DATA_W +: DATA_W] == $past(pixIn[b*DATA_W +: DATA_W]));
    // R6: lookups right after a power-down read zero
    p_lost_r6: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlStb.powerOn ##1 (gammaEn[CH] && !bankHit) |=> pixOut[b*DATA_W +: DATA_W] == '0);
    // R8: a colliding write freezes the component
    p_collide_r8: assert property (@(posedge clk) disable iff (!rstN)
      (gammaEn[CH] && bankHit) |=> $stable(pixOut[b*DATA_W +: DATA_W]));
  end
endmodule

bind gamma_lut_top gamma_lut_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .gammaEn(gammaEn), .pixIn(pixIn), .pixOut(pixOut),
  .ctrlStb(ctrlStb), .wrAddr(wrAddr)
);

// File: tb/gamma_lut_tb_top.sv
`timescale 1ns/1ps
module gamma_lut_tb_top;
  localparam int NCH  = 3;
  localparam int W    = 4;
  localparam int E    = 1 << W;
  localparam int NB   = NCH * 3;
  localparam int TOT  = NB * E;
  localparam int PIXW = NB * W;

  logic            clk = 1'b0;
  logic            rstN;
  logic            regWrEn;
  logic            regSel;
  logic [31:0]     regWrData;
  logic [NCH-1:0]  gammaEn;
  logic [PIXW-1:0] pixIn;
  logic [PIXW-1:0] pixOut;

  int tbl [TOT];
  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  gamma_lut_top #(.NUM_CH(NCH), .DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .gammaEn(gammaEn), .pixIn(pixIn), .pixOut(pixOut)
  );

  task automatic checkVal(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  function automatic int fPat(int a);
    return (a * 5 + 1) & (E - 1);
  endfunction

  function automatic logic [PIXW-1:0] mkPix(int base, int step);
    logic [PIXW-1:0] p;
    for (int k = 0; k < NB; k++) p[k*W +: W] = W'((base + k * step) & (E - 1));
    return p;
  endfunction

  function automatic int expComp(logic [PIXW-1:0] p, int k);
    int v = int'(p[k*W +: W]);
    return gammaEn[k/3] ? tbl[k*E + v] : v;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < TOT; i++) tbl[i] = 0;
  endtask

  // Called at a negedge; leaves at the next negedge.
  task automatic regAddr(int a, bit inc, bit frc);
    regWrEn = 1'b1; regSel = 1'b0;
    regWrData = {inc, frc, 30'(a)};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regData(int d);
    regWrEn = 1'b1; regSel = 1'b1; regWrData = 32'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic lookupCheck(string tag, logic [PIXW-1:0] p);
    pixIn = p;
    @(negedge clk);
    for (int k = 0; k < NB; k++)
      checkVal($sformatf("%s bank%0d", tag, k), int'(pixOut[k*W +: W]), expComp(p, k));
  endtask

  task automatic testReset();
    checkVal("R1 pixOut in reset", int'(pixOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 pixOut after reset", int'(pixOut), 0);
    regData(9);
    regData(11);
    tbl[0] = 11;
    lookupCheck("R1 index stays 0", mkPix(0, 0));
  endtask

  task automatic testLoadAll();
    regAddr(0, 1'b1, 1'b0);
    for (int a = 0; a < TOT; a++) begin
      regData(fPat(a));
      tbl[a] = fPat(a);
    end
    lookupCheck("R2 R4 lookup a", mkPix(0, 1));
    lookupCheck("R2 R4 lookup b", mkPix(5, 3));
    lookupCheck("R2 R4 lookup c", mkPix(15, 7));
    regData(14);
    tbl[0] = 14;
    lookupCheck("R3 wrap to 0", mkPix(0, 0));
    lookupCheck("R3 entry 1 intact", mkPix(1, 0));
  endtask

  task automatic testBypass();
    gammaEn = 3'b101;
    lookupCheck("R4 bypass ch1", mkPix(2, 5));
    gammaEn = 3'b111;
  endtask

  task automatic testCollide();
    logic [PIXW-1:0] p;
    int held;
    p = mkPix(0, 1);
    p[7*W +: W] = W'(3);
    regAddr(7 * E + 5, 1'b0, 1'b0);
    lookupCheck("R8 before collide", p);
    held = tbl[7 * E + 3];
    p[7*W +: W] = W'(5);
    pixIn = p;
    regWrEn = 1'b1; regSel = 1'b1; regWrData = 32'd6;
    @(negedge clk);
    regWrEn = 1'b0;
    checkVal("R8 colliding bank holds", int'(pixOut[7*W +: W]), held);
    checkVal("R8 other bank updates", int'(pixOut[6*W +: W]), expComp(p, 6));
    tbl[7 * E + 5] = 6;
    @(negedge clk);
    checkVal("R8 written value next", int'(pixOut[7*W +: W]), 6);
  endtask

  task automatic testForce();
    regAddr(0, 1'b0, 1'b1);
    gammaEn = '0;
    repeat (3) @(negedge clk);
    lookupCheck("R7 R4 bypass while forced", mkPix(4, 1));
    gammaEn = 3'b111;
    lookupCheck("R7 tables kept", mkPix(3, 2));
  endtask

  task automatic testPowerLoss();
    gammaEn = '0;
    regAddr(40, 1'b1, 1'b0);
    @(negedge clk);
    regData(9);
    clearModel();
    gammaEn = 3'b111;
    regData(12);
    tbl[41] = 12;
    lookupCheck("R5 R6 write while off dropped", mkPix(8, 0));
    lookupCheck("R5 index advanced while off", mkPix(9, 0));
    lookupCheck("R6 others zero", mkPix(2, 3));
  endtask

  task automatic testOutOfRange();
    regAddr(150, 1'b1, 1'b0);
    regData(5);
    regData(7);
    tbl[0] = 7;
    lookupCheck("R9 R3 beyond range to 0", mkPix(0, 0));
    lookupCheck("R9 no alias", mkPix(6, 0));
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
    gammaEn = 3'b111; pixIn = '0;
    clearModel();
    repeat (3) @(negedge clk);
    testReset();
    testLoadAll();
    testBypass();
    testCollide();
    testForce();
    testPowerLoss();
    testOutOfRange();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule